// File: doc/BRIEF.md
# Three-level page table walker

This block turns a 32-bit virtual address into a physical address by reading translation descriptors from memory. A request carries the virtual address, a write flag and a bypass flag. The walk starts from a context table base register and a context number, and then reads one 32-bit descriptor at a time through a read port that has only one read in flight. Each descriptor either points to the next table or ends the walk with a page entry. A walk that ends at the first, second or third table level maps a 16 MB, 256 KB or 4 KB page.

A successful walk returns the physical address of the 4 KB frame, a page size code, the final entry and the memory address that entry came from. When the entry's referenced bit is clear, or when a write finds its modified bit clear, the walker sets the missing bits and writes the entry back to its own address. A failed walk returns a fault code that holds both the level where the walk stopped and the kind of error. In bypass mode no table is read and the virtual address is returned unchanged, marked with full access.

Top module: `ptw_walker`

## Requirements
- R1: After reset `ready` is 1, and `done`, `rd_req` and `wr_req` are 0.
- R2: One cycle after a non-bypass request is accepted, `rd_req` pulses for one cycle with `rd_addr` = (`ctx_base` << 4) + (`ctx_num` << 2). No further read is issued until `rd_valid` has returned the data, and the next read, if any, follows one cycle after that.
- R3: Descriptor bits [1:0] give the type: 0 invalid, 1 table pointer, 2 page entry, 3 reserved. For a pointer, the next read address is ((descriptor with bits [1:0] cleared) << 4) + 4*index. The index is virtual address bits [31:24] after the context entry, bits [23:18] after the first-level entry, and bits [17:12] after the second-level entry. `pte_addr` reports the address of the final entry.
- R4: A page entry at level 1, 2 or 3 completes the walk with `page_size` 2 (16 MB), 1 (256 KB) or 0 (4 KB). `paddr` = (entry bits [31:8] << 12) plus the virtual address masked to bits [23:12] at level 1, to bits [17:12] at level 2, and plus nothing at level 3. `paddr[11:0]` is 0 and `full_access` is 0.
- R5: An invalid entry faults with `fault_code` = (level << 8) | (1 << 2). Level 0 is the context entry and levels 1 to 3 are the tables.
- R6: At levels 1 to 3, a reserved entry faults with (level << 8) | (4 << 2). A table pointer at level 3 faults with code 0x310.
- R7: A page entry or a reserved entry in the context table faults with code 0x010.
- R8: The referenced bit is bit 5 and the modified bit is bit 6. On success, when bit 5 is clear, or when the request is a write and bit 6 is clear, `wr_req` pulses in the same cycle as `done`. It carries `wr_addr` = `pte_addr` and `wr_data` = entry | bit 5 | (bit 6 for writes). `pte` then shows the updated entry. In every other case no write occurs and `pte` is the entry as read.
- R9: A bypass request completes one cycle after acceptance with no read. It gives `paddr` = the virtual address zero-extended, `full_access` = 1, `fault` = 0 and `page_size` = 0.
- R10: `ready` is 1 only while no walk is in progress. A request raised while `ready` is 0 is ignored and produces no `done`.
- R11: `done` is a one-cycle pulse per accepted request. `ready` is 1 in that cycle, so a request waiting in that cycle is accepted there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request, accepted when `ready` is 1 |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Request is a write access |
| req_bypass | input | 1 | Pass the address through untranslated |
| ctx_base | input | 32 | Context table base register |
| ctx_num | input | CTX_W | Context number |
| ready | output | 1 | Walker idle |
| rd_req | output | 1 | Descriptor read strobe |
| rd_addr | output | 36 | Descriptor read address |
| rd_valid | input | 1 | Read data returned |
| rd_data | input | 32 | Descriptor read data |
| wr_req | output | 1 | Entry write-back strobe |
| wr_addr | output | 36 | Write-back address |
| wr_data | output | 32 | Write-back data |
| done | output | 1 | Walk complete pulse |
| fault | output | 1 | Walk ended in a fault |
| fault_code | output | 10 | Level in [9:8], type in [7:2] |
| paddr | output | 36 | Physical address |
| page_size | output | 2 | 0: 4 KB, 1: 256 KB, 2: 16 MB |
| pte | output | 32 | Final entry, updated when written back |
| pte_addr | output | 36 | Address of the final entry |
| full_access | output | 1 | Bypass result with all permissions |

## Verification
Two pairs of events can land in the same cycle. The first is completion and entry write-back: walks are arranged so that the final entry lacks the referenced bit, or a write finds the modified bit clear. The bench then requires `wr_req`, the right address and the OR-ed data in exactly the cycle of `done`, and requires `wr_req` to stay low in every other cycle. The second is completion and a new acceptance: a request is held high while a walk is in progress and must be taken in the very cycle `done` pulses. The reference model compares `ready`, `rd_req`, `done` and `wr_req` on every clock, so a late, early or doubled event is caught.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int DESC_W = 32;
    localparam int VA_W   = 32;
    localparam int PA_W   = DESC_W + 4;
    localparam int VPN_W  = VA_W - 12;
    localparam int CODE_W = 10;
    localparam int REF_BIT = 5;
    localparam int MOD_BIT = 6;
    localparam logic [5:0] FT_INVALID = 6'd1;
    localparam logic [5:0] FT_BAD     = 6'd4;

    typedef enum logic [1:0] {
        ET_INVALID  = 2'd0,
        ET_TABLE    = 2'd1,
        ET_PAGE     = 2'd2,
        ET_RESERVED = 2'd3
    } etype_e;

    typedef enum logic [1:0] {
        K_NEXT  = 2'd0,
        K_LEAF  = 2'd1,
        K_FAULT = 2'd2
    } kind_e;

    typedef enum logic [1:0] {
        PS_4K   = 2'd0,
        PS_256K = 2'd1,
        PS_16M  = 2'd2
    } psize_e;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_WAIT = 1'b1
    } state_e;

    typedef struct packed {
        state_e              st;
        logic [1:0]          lvl;
        logic [VPN_W-1:0]    va_hi;
        logic                wr;
        logic [PA_W-1:0]     addr;
        logic                rd;
        logic                wb;
        logic [DESC_W-1:0]   wdata;
        logic                dn;
        logic                flt;
        logic [CODE_W-1:0]   code;
        logic [PA_W-1:0]     pa;
        psize_e              ps;
        logic [DESC_W-1:0]   ent;
        logic                full;
    } walk_t;
endpackage

// File: rtl/ptw_addr_calc.sv
module ptw_addr_calc
    import ptw_pkg::*;
#(
    parameter int CTX_W = 8
) (
    input  logic [DESC_W-1:0] ctx_base,
    input  logic [CTX_W-1:0]  ctx_num,
    input  logic [VPN_W-1:0]  va_hi,
    input  logic [DESC_W-3:0] ptr_field,
    input  logic [1:0]        level,
    output logic [PA_W-1:0]   root_addr,
    output logic [PA_W-1:0]   next_addr,
    output logic [PA_W-1:0]   leaf_paddr
);
    logic [7:0]  idx;
    logic [11:0] off;

    // va_hi holds virtual address bits [31:12]
    always_comb begin
        unique case (level)
            2'd0:    idx = va_hi[19:12];
            2'd1:    idx = {2'b00, va_hi[11:6]};
            default: idx = {2'b00, va_hi[5:0]};
        endcase
        unique case (level)
            2'd1:    off = va_hi[11:0];
            2'd2:    off = {6'b000000, va_hi[5:0]};
            default: off = 12'h000;
        endcase
    end

    assign root_addr  = {ctx_base, 4'b0000} + PA_W'({ctx_num, 2'b00});
    assign next_addr  = {ptr_field, 2'b00, 4'b0000} + PA_W'({idx, 2'b00});
    assign leaf_paddr = {ptr_field[DESC_W-3:6], 12'h000} + PA_W'({off, 12'h000});
endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
    import ptw_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    input  logic [1:0]        level,
    input  logic              is_write,
    output kind_e             kind,
    output logic [CODE_W-1:0] code,
    output psize_e            psize,
    output logic              need_wb,
    output logic [DESC_W-1:0] new_desc
);
    always_comb begin
        kind = K_FAULT;
        code = {level, FT_BAD, 2'b00};
        unique case (etype_e'(desc[1:0]))
            ET_INVALID: code = {level, FT_INVALID, 2'b00};
            ET_TABLE:   if (level != 2'd3) kind = K_NEXT;
            ET_PAGE:    if (level != 2'd0) kind = K_LEAF;
            default:    kind = K_FAULT;
        endcase
        unique case (level)
            2'd1:    psize = PS_16M;
            2'd2:    psize = PS_256K;
            default: psize = PS_4K;
        endcase
    end

    assign need_wb = !desc[REF_BIT] || (is_write && !desc[MOD_BIT]);
    assign new_desc = desc | (DESC_W'(1) << REF_BIT) | (DESC_W'(is_write) << MOD_BIT);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int CTX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic              req_bypass,
    input  logic [DESC_W-1:0] ctx_base,
    input  logic [CTX_W-1:0]  ctx_num,
    output logic              ready,
    output logic              rd_req,
    output logic [PA_W-1:0]   rd_addr,
    input  logic              rd_valid,
    input  logic [DESC_W-1:0] rd_data,
    output logic              wr_req,
    output logic [PA_W-1:0]   wr_addr,
    output logic [DESC_W-1:0] wr_data,
    output logic              done,
    output logic              fault,
    output logic [CODE_W-1:0] fault_code,
    output logic [PA_W-1:0]   paddr,
    output logic [1:0]        page_size,
    output logic [DESC_W-1:0] pte,
    output logic [PA_W-1:0]   pte_addr,
    output logic              full_access
);
    walk_t cur_q, nx_d;

    logic [PA_W-1:0]   root_addr, next_addr, leaf_paddr;
    kind_e             kind;
    logic [CODE_W-1:0] chk_code;
    psize_e            chk_ps;
    logic              need_wb;
    logic [DESC_W-1:0] new_desc;

    ptw_addr_calc #(.CTX_W(CTX_W)) u_addr (
        .ctx_base   (ctx_base),
        .ctx_num    (ctx_num),
        .va_hi      (cur_q.va_hi),
        .ptr_field  (rd_data[DESC_W-1:2]),
        .level      (cur_q.lvl),
        .root_addr  (root_addr),
        .next_addr  (next_addr),
        .leaf_paddr (leaf_paddr)
    );

    ptw_entry_check u_chk (
        .desc     (rd_data),
        .level    (cur_q.lvl),
        .is_write (cur_q.wr),
        .kind     (kind),
        .code     (chk_code),
        .psize    (chk_ps),
        .need_wb  (need_wb),
        .new_desc (new_desc)
    );

    always_comb begin
        nx_d    = cur_q;
        nx_d.rd = 1'b0;
        nx_d.wb = 1'b0;
        nx_d.dn = 1'b0;
        unique case (cur_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    nx_d.va_hi = req_vaddr[VA_W-1:12];
                    nx_d.wr    = req_write;
                    nx_d.lvl   = 2'd0;
                    if (req_bypass) begin
                        nx_d.dn   = 1'b1;
                        nx_d.flt  = 1'b0;
                        nx_d.code = '0;
                        nx_d.pa   = PA_W'(req_vaddr);
                        nx_d.ps   = PS_4K;
                        nx_d.ent  = '0;
                        nx_d.addr = '0;
                        nx_d.full = 1'b1;
                    end else begin
                        nx_d.addr = root_addr;
                        nx_d.rd   = 1'b1;
                        nx_d.st   = S_WAIT;
                    end
                end
            end
            default: begin
                if (rd_valid) begin
                    unique case (kind)
                        K_NEXT: begin
                            nx_d.addr = next_addr;
                            nx_d.rd   = 1'b1;
                            nx_d.lvl  = cur_q.lvl + 2'd1;
                        end
                        K_LEAF: begin
                            nx_d.st    = S_IDLE;
                            nx_d.dn    = 1'b1;
                            nx_d.flt   = 1'b0;
                            nx_d.code  = '0;
                            nx_d.pa    = leaf_paddr;
                            nx_d.ps    = chk_ps;
                            nx_d.ent   = need_wb ? new_desc : rd_data;
                            nx_d.full  = 1'b0;
                            nx_d.wb    = need_wb;
                            nx_d.wdata = new_desc;
                        end
                        default: begin
                            nx_d.st   = S_IDLE;
                            nx_d.dn   = 1'b1;
                            nx_d.flt  = 1'b1;
                            nx_d.code = chk_code;
                            nx_d.full = 1'b0;
                        end
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nx_d;
    end

    assign ready       = (cur_q.st == S_IDLE);
    assign rd_req      = cur_q.rd;
    assign rd_addr     = cur_q.addr;
    assign wr_req      = cur_q.wb;
    assign wr_addr     = cur_q.addr;
    assign wr_data     = cur_q.wdata;
    assign done        = cur_q.dn;
    assign fault       = cur_q.flt;
    assign fault_code  = cur_q.code;
    assign paddr       = cur_q.pa;
    assign page_size   = cur_q.ps;
    assign pte         = cur_q.ent;
    assign pte_addr    = cur_q.addr;
    assign full_access = cur_q.full;

    // R2
    read_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !ready);

    // R8
    wb_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (done && !fault && wr_data[REF_BIT] && wr_addr == pte_addr));

    // R5
    fault_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (fault_code[1:0] == 2'b00 &&
                             (fault_code[7:2] == FT_INVALID || fault_code[7:2] == FT_BAD)));

    // R9
    bypass_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && full_access) |-> (!fault && $past(req_valid && ready && req_bypass)));

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ready);
endmodule

// File: tb/ptw_walker_bench.sv
`timescale 1ns/1ps
module ptw_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_bypass = 1'b0;
    logic [31:0] ctx_base = 32'h0000_1000;
    logic [7:0]  ctx_num = 8'd3;
    logic        ready;
    logic        rd_req;
    logic [35:0] rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        wr_req;
    logic [35:0] wr_addr;
    logic [31:0] wr_data;
    logic        done;
    logic        fault;
    logic [9:0]  fault_code;
    logic [35:0] paddr;
    logic [1:0]  page_size;
    logic [31:0] pte;
    logic [35:0] pte_addr;
    logic        full_access;

    always #2.5 clk = ~clk;

    ptw_walker #(.CTX_W(8)) u_ptw_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_bypass(req_bypass), .ctx_base(ctx_base),
        .ctx_num(ctx_num), .ready(ready), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(mem_rd_valid), .rd_data(mem_rd_data), .wr_req(wr_req),
        .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .fault(fault),
        .fault_code(fault_code), .paddr(paddr), .page_size(page_size), .pte(pte),
        .pte_addr(pte_addr), .full_access(full_access)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int lat = 0;

    logic [31:0] mem [longint];
    longint      exp_rd_q [$];
    int          reads_left = 0;
    int          reads_seen = 0;
    int          pend = -1;
    longint      pend_addr = 0;
    bit          busy_m = 0;
    bit          exp_rd_next = 0;
    bit          exp_done_next = 0;
    bit          cur_byp = 0;
    bit          exp_fault = 0;
    logic [9:0]  exp_code = '0;
    logic [35:0] exp_pa = '0;
    logic [1:0]  exp_ps = '0;
    logic [31:0] exp_pte = '0;
    logic [35:0] exp_pte_addr = '0;
    bit          exp_full = 0;
    bit          exp_wb = 0;
    logic [31:0] exp_wb_data = '0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] rd_mem(input longint a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    function automatic logic [31:0] f_ptr(input longint t);
        return 32'(t >> 4) | 32'h1;
    endfunction

    function automatic logic [31:0] f_leaf(input longint pa, input logic [7:0] fl);
        return 32'((pa >> 12) << 8) | {24'h0, fl} | 32'h2;
    endfunction

    // Behavioural walk over the bench memory, from the requirement text
    task automatic model_walk(input logic [31:0] va, input bit w, input bit b,
                              input logic [31:0] cb, input logic [7:0] cn);
        longint a;
        logic [31:0] d;
        bit stop;
        longint off;
        exp_rd_q.delete();
        reads_left = 0;
        reads_seen = 0;
        exp_fault = 0;
        exp_code = '0;
        exp_wb = 0;
        exp_full = b;
        cur_byp = b;
        if (b) begin
            exp_pa = 36'(va);
            exp_ps = 2'd0;
            return;
        end
        a = (longint'(cb) << 4) + (longint'(cn) << 2);
        stop = 0;
        for (int lv = 0; lv < 4 && !stop; lv++) begin
            d = rd_mem(a);
            exp_rd_q.push_back(a);
            reads_left++;
            if (d[1:0] == 2'd0) begin
                exp_fault = 1; exp_code = 10'((lv << 8) | 4); stop = 1;
            end else if (d[1:0] == 2'd3 || (d[1:0] == 2'd2 && lv == 0) ||
                         (d[1:0] == 2'd1 && lv == 3)) begin
                exp_fault = 1; exp_code = 10'((lv << 8) | 16); stop = 1;
            end else if (d[1:0] == 2'd1) begin
                longint ix;
                if (lv == 0)      ix = longint'(va >> 24);
                else if (lv == 1) ix = longint'((va >> 18) & 32'h3f);
                else              ix = longint'((va >> 12) & 32'h3f);
                a = (longint'(d & ~32'h3) << 4) + 4 * ix;
            end else begin
                stop = 1;
                exp_ps = (lv == 1) ? 2'd2 : (lv == 2) ? 2'd1 : 2'd0;
                off = (lv == 1) ? longint'(va & 32'h00ff_f000) :
                      (lv == 2) ? longint'(va & 32'h0003_f000) : 0;
                exp_pa = 36'((longint'(d >> 8) << 12) + off);
                exp_wb = !d[5] || (w && !d[6]);
                exp_wb_data = d | 32'h20 | (w ? 32'h40 : 32'h0);
                exp_pte = exp_wb ? exp_wb_data : d;
                exp_pte_addr = 36'(a);
            end
        end
    endtask

    // Per-clock reference comparison and memory responder
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit dn_now;
            bit rd_now;
            dn_now = exp_done_next;
            rd_now = exp_rd_next;
            chk(done == dn_now, "R11", done, dn_now);
            chk(rd_req == rd_now, cur_byp ? "R9" : "R2", rd_req, rd_now);
            chk(wr_req == (dn_now && exp_wb && !exp_fault), "R8", wr_req, dn_now && exp_wb);
            if (done && dn_now) begin
                chk(fault == exp_fault, exp_fault ? "R5" : "R4", fault, exp_fault);
                if (exp_fault) begin
                    chk(fault_code == exp_code,
                        (exp_code == 10'h010) ? "R7" : (exp_code[7:2] == 6'd1) ? "R5" : "R6",
                        fault_code, exp_code);
                end else begin
                    chk(paddr == exp_pa, cur_byp ? "R9" : "R4", paddr, exp_pa);
                    chk(page_size == exp_ps, cur_byp ? "R9" : "R4", page_size, exp_ps);
                    chk(full_access == exp_full, cur_byp ? "R9" : "R4", full_access, exp_full);
                    if (!cur_byp) begin
                        chk(pte == exp_pte, "R8", pte, exp_pte);
                        chk(pte_addr == exp_pte_addr, "R3", pte_addr, exp_pte_addr);
                    end
                end
                if (wr_req) begin
                    chk(wr_addr == exp_pte_addr, "R8", wr_addr, exp_pte_addr);
                    chk(wr_data == exp_wb_data, "R8", wr_data, exp_wb_data);
                end
                if (exp_wb && !exp_fault && !cur_byp) mem[longint'(exp_pte_addr)] = exp_wb_data;
            end
            if (dn_now) busy_m = 0;
            chk(ready == !busy_m, "R10", ready, !busy_m);
            mem_rd_valid = 1'b0;
            exp_rd_next = 0;
            exp_done_next = 0;
            if (rd_req) begin
                if (exp_rd_q.size() == 0) begin
                    chk(0, "R2", rd_addr, 0);
                end else begin
                    longint ea;
                    ea = exp_rd_q.pop_front();
                    chk(longint'(rd_addr) == ea, (reads_seen == 0) ? "R2" : "R3", rd_addr, ea);
                end
                reads_seen++;
                pend = lat;
                pend_addr = longint'(rd_addr);
            end
            if (pend == 0) begin
                mem_rd_valid = 1'b1;
                mem_rd_data = rd_mem(pend_addr);
                reads_left--;
                if (reads_left <= 0) exp_done_next = 1;
                else                 exp_rd_next = 1;
                pend = -1;
            end else if (pend > 0) begin
                pend--;
            end
            if (req_valid && ready) begin
                model_walk(req_vaddr, req_write, req_bypass, ctx_base, ctx_num);
                busy_m = 1;
                if (req_bypass) exp_done_next = 1;
                else            exp_rd_next = 1;
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic issue(input logic [31:0] va, input bit w, input bit b, input logic [7:0] cn);
        @(posedge clk); #1;
        req_valid = 1'b1; req_vaddr = va; req_write = w; req_bypass = b; ctx_num = cn;
        do @(negedge clk); while (!ready);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy_m);
    endtask

    task automatic walk(input logic [31:0] va, input bit w, input bit b, input logic [7:0] cn);
        issue(va, w, b, cn);
        wait_idle();
    endtask

    localparam logic [31:0] VA_A = 32'h1234_5000;
    localparam logic [31:0] VA_B = 32'h128A_B000;
    localparam logic [31:0] VA_C = 32'h7ABC_D000;

    initial begin
        mem[64'h1000C] = f_ptr(64'h20000);
        mem[64'h10010] = 32'h0;
        mem[64'h10014] = f_leaf(64'h5000, 8'h20);
        mem[64'h10018] = 32'h3;
        mem[64'h20000 + 4 * 64'h12] = f_ptr(64'h30000);
        mem[64'h20000 + 4 * 64'h13] = 32'h3;
        mem[64'h20000 + 4 * 64'h7A] = f_leaf(64'h2_0000_0000, 8'h20);
        mem[64'h30000 + 4 * 64'(((VA_A >> 18) & 32'h3f))] = f_ptr(64'h40000);
        mem[64'h40000 + 4 * 64'(((VA_A >> 12) & 32'h3f))] = f_leaf(64'h8_7654_3000, 8'h00);
        mem[64'h30000 + 4 * 64'h22] = f_leaf(64'h1_0004_0000, 8'h60);
        mem[64'h30000 + 4 * 64'h01] = f_ptr(64'h50000);
        mem[64'h30000 + 4 * 64'h02] = 32'h3;
        mem[64'h50000] = f_ptr(64'h60000);

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ready == 1'b1, "R1", ready, 1);
        chk(done == 1'b0, "R1", done, 0);
        chk(rd_req == 1'b0, "R1", rd_req, 0);
        chk(wr_req == 1'b0, "R1", wr_req, 0);

        lat = 0;
        walk(VA_A, 0, 0, 8'd3);          // R4 4 KB, R8 referenced bit set
        walk(VA_A, 0, 0, 8'd3);          // R8 no write-back now
        lat = 2;
        walk(VA_A, 1, 0, 8'd3);          // R8 modified bit set on write
        walk(VA_B, 1, 0, 8'd3);          // R4 256 KB, bits already set
        walk(VA_C, 1, 0, 8'd3);          // R4 16 MB with write-back
        lat = 1;
        walk(32'h0000_0000, 0, 0, 8'd4); // R5 invalid context entry
        walk(32'h0000_0000, 0, 0, 8'd5); // R7 page entry in context table
        walk(32'h0000_0000, 0, 0, 8'd6); // R7 reserved context entry
        walk(32'h1300_0000, 0, 0, 8'd3); // R6 reserved at level 1
        walk(32'h1400_0000, 0, 0, 8'd3); // R5 invalid at level 1
        walk(32'h12FC_0000, 0, 0, 8'd3); // R5 invalid at level 2
        walk(32'h1208_0000, 0, 0, 8'd3); // R6 reserved at level 2
        walk(32'h1204_0000, 0, 0, 8'd3); // R6 pointer at level 3
        walk(32'h1204_1000, 0, 0, 8'd3); // R5 invalid at level 3
        walk(32'hDEAD_BEEF, 1, 1, 8'd3); // R9 bypass

        // R10 a request pulsed while busy is dropped
        lat = 3;
        issue(VA_B, 0, 0, 8'd3);
        @(posedge clk); #1;
        req_valid = 1'b1; req_bypass = 1'b1; req_vaddr = 32'h0BAD_0000;
        @(posedge clk); #1;
        req_valid = 1'b0; req_bypass = 1'b0;
        wait_idle();
        repeat (3) @(negedge clk);

        // R11 a held request is taken in the done cycle
        lat = 0;
        issue(VA_C, 0, 0, 8'd3);
        issue(32'h0000_ABCD, 0, 1, 8'd3);
        wait_idle();
        issue(VA_A, 1, 0, 8'd3);
        issue(VA_B, 0, 0, 8'd3);
        wait_idle();
        repeat (4) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired R11 actual=%0h expected=%0h", 0, 1);
        finish_run();
    end
endmodule